// File: doc/BRIEF.md
# Filtered Shutdown Request Input Detector

This block watches a small set of active-low shutdown request pins and turns each one into a sticky request flag. Each pin has its own two-bit qualification mode. In edge mode a single falling edge is enough. In the three level modes the pin must be seen low on sixteen sample strobes in a row. The strobes come from one of three prescaled rates of the block clock: divide by 8, 16 or 128. A glitch shorter than the chosen window is rejected.

Every pin first passes through a two-flop synchronizer. A free-running prescaler supplies one single-cycle strobe per rate. A small register port holds the mode fields and the interrupt enable, and it lets software read and clear the flags. The interrupt line is the OR of all flags, gated by the enable, and it is registered once.

Top module: `shdn_req_detect`

## Requirements
- R1: With a pin's mode at 00, a falling edge on that pin (seen after the synchronizer) sets that pin's flag. Flag bits sit at address 1, bit i for pin i, i = 0..2. Even a one-cycle low pulse sets it.
- R2: With mode 01, the flag is set once 16 consecutive samples taken every 8 clocks are all low. A low stretch of exactly 120 clocks does not set it. A stretch of exactly 128 clocks does.
- R3: With mode 10, the same rule applies with a sample every 16 clocks. A stretch of 240 clocks does not set the flag; one of 256 clocks does.
- R4: With mode 11, the same rule applies with a sample every 128 clocks. A stretch of 1920 clocks does not set the flag; one of 2048 clocks does.
- R5: In a level mode, any sample that finds the pin high restarts the low-sample count from zero. Two 15-sample low runs separated by one high sample set no flag.
- R6: In a level mode, the count holds at 16 while the pin stays low. Once a flag set during one continuous low stretch is cleared, that stretch does not set it again.
- R7: Flags are sticky. A flag is cleared only by a read of address 1 that returns it as 1, followed by a write to address 1 with that bit at 0. Bits written as 1 keep their value. A write of 0 with no read before it leaves the flag set.
- R8: If a request arrives in the same cycle as a clearing write to its flag, the flag stays set.
- R9: `irq` equals (interrupt enable AND any flag set), one clock after that condition. The interrupt enable is bit 8 of address 0.
- R10: Address 0 holds the pin 2 mode in bits 7:6, the pin 1 mode in bits 5:4, the pin 0 mode in bits 3:2 and the enable in bit 8. All of these reset to 0. Every other bit at either address reads as 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the prescaler divides this clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 3 | Asynchronous active-low shutdown request pins, bit i is pin i |
| bus_addr | input | 1 | Register select: 0 control, 1 flags |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; arms flag clearing when it reads address 1 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every pin through every level mode using low stretches one sample period shorter than the window and exactly as long as it. A qualifier that counted one sample too few or too many, or used the wrong rate, fails on one side of that boundary. It splits a low run with one high sample, to catch a counter that pauses instead of restarting. It also clears a flag in the middle of a held low, to catch a counter that wraps and sets the flag again. Finally, it times a new edge to land on the clearing write and times the interrupt edge to the exact cycle. A design that let the clear win, or that left the interrupt unregistered, shows up as a wrong flag value or an `irq` one cycle early.

// File: rtl/shdn_pkg.sv
package shdn_pkg;

    localparam int unsigned NUM_RATES = 3;
    localparam int unsigned REG_W     = 16;

    typedef enum logic [1:0] {
        QM_EDGE  = 2'b00,
        QM_SLOW0 = 2'b01,
        QM_SLOW1 = 2'b10,
        QM_SLOW2 = 2'b11
    } qual_mode_e;

    typedef enum logic {
        RA_CTRL = 1'b0,
        RA_FLAG = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic lvl;
        logic fall;
        logic hit;
    } pin_obs_t;

    function automatic int unsigned mode_lo_bit();
        return 2;
    endfunction

    function automatic int unsigned enable_bit(input int unsigned npins);
        return 2 * npins + 2;
    endfunction

    function automatic logic rate_pick(input qual_mode_e m,
                                       input logic [NUM_RATES-1:0] stb);
        case (m)
            QM_SLOW0: return stb[0];
            QM_SLOW1: return stb[1];
            QM_SLOW2: return stb[2];
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/shdn_prescaler.sv
module shdn_prescaler
    import shdn_pkg::*;
#(
    parameter int unsigned DIV_A = 8,
    parameter int unsigned DIV_B = 16,
    parameter int unsigned DIV_C = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [NUM_RATES-1:0] stb
);
    localparam int unsigned CW = $clog2(DIV_C);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam int unsigned LG = (g == 0) ? $clog2(DIV_A) :
                                     (g == 1) ? $clog2(DIV_B) : $clog2(DIV_C);
        assign stb[g] = &cnt_q[LG-1:0];
    end

endmodule

// File: rtl/shdn_pin_qual.sv
module shdn_pin_qual
    import shdn_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LOW_RUN     = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pin_n,
    input  qual_mode_e           mode,
    input  logic [NUM_RATES-1:0] stb,
    output logic                 req
);
    localparam int unsigned RW      = $clog2(LOW_RUN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(LOW_RUN);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_d;
    logic [RW-1:0]          run_q;
    logic                   tick;
    pin_obs_t               obs;

    // two-stage synchronizer, idles high (inactive)
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign tick = rate_pick(mode, stb);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d <= 1'b1;
            run_q <= '0;
        end else begin
            lvl_d <= obs.lvl;
            if (mode == QM_EDGE) begin
                run_q <= '0;
            end else if (tick) begin
                if (obs.lvl)              run_q <= '0;
                else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
            end
        end
    end

    always_comb begin
        obs.lvl  = sync_q[SYNC_STAGES-1];
        obs.fall = lvl_d & ~obs.lvl;
        obs.hit  = tick & ~obs.lvl & (run_q == RUN_MAX - 1'b1);
        req      = (mode == QM_EDGE) ? obs.fall : obs.hit;
    end

endmodule

// File: rtl/shdn_regs.sv
module shdn_regs
    import shdn_pkg::*;
#(
    parameter int unsigned NUM_PINS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_req,
    output logic [2*NUM_PINS-1:0] mode_vec,
    output logic [NUM_PINS-1:0]   flags,
    output logic                  ie,
    output logic                  irq
);
    localparam int unsigned MODE_LO = mode_lo_bit();
    localparam int unsigned MODE_HI = MODE_LO + 2 * NUM_PINS - 1;
    localparam int unsigned IE_BIT  = enable_bit(NUM_PINS);

    logic [2*NUM_PINS-1:0] mode_q;
    logic                  ie_q;
    logic [NUM_PINS-1:0]   flag_q;
    logic [NUM_PINS-1:0]   arm_q;
    logic [NUM_PINS-1:0]   flag_d;
    logic                  irq_q;
    logic                  sel_ctrl;
    logic                  sel_flag;
    logic                  unused_wbits;

    assign sel_ctrl     = (reg_addr_e'(bus_addr) == RA_CTRL);
    assign sel_flag     = (reg_addr_e'(bus_addr) == RA_FLAG);
    assign unused_wbits = ^bus_wdata[REG_W-1:IE_BIT+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ie_q   <= 1'b0;
        end else if (bus_wr && sel_ctrl) begin
            mode_q <= bus_wdata[MODE_HI:MODE_LO];
            ie_q   <= bus_wdata[IE_BIT];
        end
    end

    // clear only armed bits written 0; new requests override the clear
    always_comb begin
        flag_d = flag_q;
        if (bus_wr && sel_flag)
            flag_d = flag_q & ~(arm_q & ~bus_wdata[NUM_PINS-1:0]);
        flag_d = flag_d | pin_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            arm_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (bus_wr && sel_flag)      arm_q <= '0;
            else if (bus_rd && sel_flag) arm_q <= flag_q;
            irq_q <= ie_q & (|flag_q);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[MODE_HI:MODE_LO] = mode_q;
            bus_rdata[IE_BIT]          = ie_q;
        end else begin
            bus_rdata[NUM_PINS-1:0] = flag_q;
        end
    end

    assign mode_vec = mode_q;
    assign flags    = flag_q;
    assign ie       = ie_q;
    assign irq      = irq_q;

endmodule

// File: rtl/shdn_req_detect.sv
module shdn_req_detect
    import shdn_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LOW_RUN     = 16,
    parameter int unsigned DIV_A       = 8,
    parameter int unsigned DIV_B       = 16,
    parameter int unsigned DIV_C       = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] shdn_n,
    input  logic                bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic                irq
);
    logic [NUM_RATES-1:0]  rate_stb;
    logic [NUM_PINS-1:0]   pin_req;
    logic [NUM_PINS-1:0]   flag_vec;
    logic [2*NUM_PINS-1:0] mode_vec;
    logic                  ctrl_ie;

    shdn_prescaler #(
        .DIV_A(DIV_A),
        .DIV_B(DIV_B),
        .DIV_C(DIV_C)
    ) u_presc (
        .clk (clk),
        .rst (rst),
        .stb (rate_stb)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        shdn_pin_qual #(
            .SYNC_STAGES(SYNC_STAGES),
            .LOW_RUN    (LOW_RUN)
        ) u_qual (
            .clk   (clk),
            .rst   (rst),
            .pin_n (shdn_n[p]),
            .mode  (qual_mode_e'(mode_vec[2*p +: 2])),
            .stb   (rate_stb),
            .req   (pin_req[p])
        );
    end

    shdn_regs #(
        .NUM_PINS(NUM_PINS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_req   (pin_req),
        .mode_vec  (mode_vec),
        .flags     (flag_vec),
        .ie        (ctrl_ie),
        .irq       (irq)
    );

endmodule

// File: rtl/shdn_req_detect_chk.sv
module shdn_req_detect_chk
    import shdn_pkg::*;
#(
    parameter int unsigned NUM_PINS = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_addr,
    input logic                 bus_wr,
    input logic [REG_W-1:0]     bus_rdata,
    input logic [NUM_PINS-1:0]  flag_vec,
    input logic [NUM_PINS-1:0]  pin_req,
    input logic                 ctrl_ie,
    input logic                 irq,
    input logic [NUM_RATES-1:0] rate_stb
);
    localparam int unsigned IE_BIT = enable_bit(NUM_PINS);

    // R7
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr) |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec)));

    // R1
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_vec & ~$past(flag_vec) & ~$past(pin_req)) == '0));

    // R9
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(ctrl_ie) && ($past(flag_vec) != '0)));

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_addr |-> (bus_rdata[REG_W-1:IE_BIT+1] == '0 && bus_rdata[1:0] == 2'b00));

    // R4
    rate_nest_chk: assert property (@(posedge clk) disable iff (rst)
        rate_stb[2] |-> (rate_stb[1] && rate_stb[0]));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_req != '0) |=> ((flag_vec & $past(pin_req)) == $past(pin_req)));

endmodule

bind shdn_req_detect shdn_req_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .flag_vec  (flag_vec),
    .pin_req   (pin_req),
    .ctrl_ie   (ctrl_ie),
    .irq       (irq),
    .rate_stb  (rate_stb)
);

// File: tb/shdn_req_detect_tb.sv
`timescale 1ns/1ps
module shdn_req_detect_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  shdn_n = 3'b111;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    shdn_req_detect u_dut (
        .clk       (clk),
        .rst       (rst),
        .shdn_n    (shdn_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clear_all();
        logic [15:0] d;
        bus_read(1'b1, d);
        bus_write(1'b1, 16'h0000);
    endtask

    function automatic logic [15:0] ctrl_word(input int pin, input int mode, input logic en);
        logic [15:0] w = '0;
        w[2*pin+2 +: 2] = mode[1:0];
        w[8] = en;
        return w;
    endfunction

    task automatic low_run(input int pin, input int len);
        shdn_n[pin] = 1'b0;
        tick(len);
        shdn_n[pin] = 1'b1;
    endtask

    initial begin
        logic [15:0] d;
        tick(5);
        rst = 1'b0;
        tick(2);

        // R10 reset state
        bus_read(1'b0, d); chk("R10 ctrl reset", d, 16'h0000);
        bus_read(1'b1, d); chk("R10 flags reset", d, 16'h0000);
        chk("R9 irq reset", irq, 1'b0);
        bus_write(1'b0, 16'hFFFF);
        bus_read(1'b0, d); chk("R10 reserved bits read 0", d, 16'h01FC);
        bus_write(1'b1, 16'hFFFF);
        bus_read(1'b1, d); chk("R10 flag reg upper bits", d, 16'h0000);
        bus_write(1'b0, 16'h0000);
        bus_read(1'b0, d); chk("R10 ctrl cleared", d, 16'h0000);

        // R1 edge mode on each pin, one-cycle pulse
        for (int p = 0; p < 3; p++) begin
            low_run(p, 1);
            tick(6);
            bus_read(1'b1, d); chk("R1 edge pulse sets flag", d, 16'(1 << p));
            bus_write(1'b1, 16'h0000);
            bus_read(1'b1, d); chk("R7 read-then-write clears", d, 16'h0000);
            bus_write(1'b1, 16'h0000);
        end

        // R2/R3/R4 window boundary sweep
        for (int p = 0; p < 3; p++) begin
            for (int m = 1; m < 4; m++) begin
                int dv;
                string tg;
                dv = (m == 1) ? 8 : (m == 2) ? 16 : 128;
                tg = (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
                bus_write(1'b0, ctrl_word(p, m, 1'b0));
                tick(2 * dv + 20);
                low_run(p, 15 * dv);
                tick(2 * dv + 20);
                bus_read(1'b1, d); chk({tg, " 15 samples no flag"}, d, 16'h0000);
                low_run(p, 16 * dv);
                tick(2 * dv + 20);
                bus_read(1'b1, d); chk({tg, " 16 samples sets flag"}, d, 16'(1 << p));
                bus_write(1'b1, 16'h0000);
            end
        end

        // R5 high sample restarts count
        bus_write(1'b0, ctrl_word(0, 1, 1'b0));
        tick(40);
        low_run(0, 120);
        tick(8);
        low_run(0, 120);
        tick(40);
        bus_read(1'b1, d); chk("R5 split run no flag", d, 16'h0000);
        bus_write(1'b1, 16'h0000);

        // R6 saturation: clear during held low, no second set
        bus_write(1'b0, ctrl_word(1, 1, 1'b0));
        tick(40);
        shdn_n[1] = 1'b0;
        tick(200);
        bus_read(1'b1, d); chk("R6 flag set during hold", d, 16'h0002);
        bus_write(1'b1, 16'h0000);
        tick(400);
        shdn_n[1] = 1'b1;
        tick(40);
        bus_read(1'b1, d); chk("R6 no re-set while held", d, 16'h0000);
        bus_write(1'b1, 16'h0000);

        // R7 write without read, partial clear
        bus_write(1'b0, 16'h0000);
        tick(4);
        low_run(2, 1);
        tick(6);
        bus_write(1'b1, 16'h0000);
        bus_read(1'b1, d); chk("R7 unarmed write keeps flag", d, 16'h0004);
        bus_write(1'b1, 16'h0000);
        low_run(0, 1);
        low_run(2, 1);
        tick(6);
        bus_read(1'b1, d); chk("R7 two flags set", d, 16'h0005);
        bus_write(1'b1, 16'h0003);
        bus_read(1'b1, d); chk("R7 only zero-written bit cleared", d, 16'h0001);
        bus_write(1'b1, 16'h0000);

        // R8 set wins over clear in the same cycle
        low_run(0, 1);
        tick(6);
        bus_read(1'b1, d); chk("R8 flag set before race", d, 16'h0001);
        shdn_n[0] = 1'b0;
        tick(2);
        bus_addr = 1'b1; bus_wdata = 16'hFFFE; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        shdn_n[0] = 1'b1;
        tick(4);
        bus_read(1'b1, d); chk("R8 set wins", d, 16'h0001);
        bus_write(1'b1, 16'h0000);
        bus_read(1'b1, d); chk("R8 later clear works", d, 16'h0000);
        bus_write(1'b1, 16'h0000);

        // R9 interrupt gating and timing
        low_run(0, 1);
        tick(10);
        chk("R9 irq off while disabled", irq, 1'b0);
        bus_write(1'b0, 16'h0100);
        chk("R9 irq not yet", irq, 1'b0);
        tick(1);
        chk("R9 irq one cycle later", irq, 1'b1);
        bus_read(1'b1, d);
        bus_write(1'b1, 16'h0000);
        chk("R9 irq holds one cycle", irq, 1'b1);
        tick(1);
        chk("R9 irq drops after clear", irq, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule